// File: doc/BRIEF.md
# Clear-to-Send Change-of-State Monitor

This block watches a clear-to-send line that arrives from off chip, is active low and has no relation to the block's clock. The line passes through a two-stage synchronizer and then a glitch filter. The filter accepts a new level only after the line has held it for a set number of clock cycles, a window sized to the 25–50 µs range. The block has one read-only 8-bit status register. It reports the filtered level in bit 0 with inverted sense and a sticky change-of-state flag in bit 4.

Reading the status register clears the flag. An auxiliary control register can be written, and its bit 0 routes the flag to an interrupt request. After reset, the current-state bit waits for two serial-clock ticks before it follows the line. At that moment, if the line is already asserted, the flag is raised even though no transition was seen.

Top module: `cts_cos_monitor`

## Requirements
- R1: After reset the status register reads 0x01 (flag clear, line reported negated), the interrupt enable is 0 and `irq` is low.
- R2: Status bit 0 stays 1 until the second `ser_tick` pulse after reset. From the clock edge that samples that pulse onward, bit 0 equals the accepted line level: 0 when the line is asserted (low), 1 when it is negated (high).
- R3: At the edge that samples the second `ser_tick` after reset, the flag (status bit 4) is set if the synchronized line is low, and stays clear if it is high.
- R4: Once armed, suppose the line changes in either direction and holds the new level for at least `FILT_CYCLES` clock cycles. Then bit 0 takes the new value and the flag sets together, right after the (`FILT_CYCLES`+2)th rising edge that follows the change.
- R5: A pulse on the line that lasts `FILT_CYCLES`-1 clock cycles or fewer changes neither bit 0 nor the flag.
- R6: `stat_rdata` always shows the register's present contents. The flag clears at the rising edge that samples `stat_rd` high, so the read returns the value from before the clear.
- R7: If a qualified change and a status read fall on the same edge, the flag ends set.
- R8: Bit 0 of the `aux_wdata` byte, written when `aux_wr` is high, is the interrupt enable. `irq` is high exactly while the flag and that enable are both 1.
- R9: Status bits 7 to 5 and 3 to 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_tick | input | 1 | One-cycle pulse per serial-clock period |
| cts_n_async | input | 1 | Raw clear-to-send line, active low, asynchronous |
| stat_rd | input | 1 | Status register read strobe (clears the flag) |
| stat_rdata | output | 8 | Status register contents |
| aux_wr | input | 1 | Auxiliary control register write strobe |
| aux_wdata | input | 8 | Auxiliary control write data, bit 0 is the interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
A line change driven on a falling edge shows up in the status register right after the `FILT_CYCLES`+2th rising edge. That is two synchronizer stages plus `FILT_CYCLES` cycles of filter count. The bench samples at the falling edge before that point, where it expects the old value, and at the one after, where it expects the new value. The effect of a read strobe and of the arming tick appears at the falling edge right after the rising edge that sampled it, and `irq` follows the flag and the enable in the same cycle. The random pulses and the same-edge read are placed by counting those falling edges, so each result is sampled in the cycle the requirement names.

// File: rtl/cts_mon_pkg.sv
package cts_mon_pkg;

  localparam int STAT_W   = 8;
  localparam int FLAG_BIT = 4;
  localparam int LVL_BIT  = 0;
  localparam int EN_BIT   = 0;

  // Build the status byte: every bit not named here reads 0.
  function automatic logic [STAT_W-1:0] pack_status(input logic flag, input logic lvl);
    logic [STAT_W-1:0] r;
    r           = '0;
    r[FLAG_BIT] = flag;
    r[LVL_BIT]  = lvl;
    return r;
  endfunction

  // Next value of the sticky flag: a set outranks a clearing read.
  function automatic logic next_flag(input logic cur, input logic set_ev, input logic clr_rd);
    if (set_ev)      return 1'b1;
    else if (clr_rd) return 1'b0;
    else             return cur;
  endfunction

endpackage

// File: rtl/cts_sync.sv
module cts_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RESET_VAL;
          else        chain_q[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= RESET_VAL;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/cts_startup_arm.sv
module cts_startup_arm #(
  parameter int ARM_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_tick,
  output logic armed,
  output logic arm_evt
);

  localparam int TW = $clog2(ARM_TICKS + 1);
  localparam logic [TW-1:0] LAST_TICK = TW'(ARM_TICKS - 1);

  logic [TW-1:0] tick_cnt_q;
  logic          armed_q;

  assign arm_evt = !armed_q && ser_tick && (tick_cnt_q == LAST_TICK);
  assign armed   = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt_q <= '0;
      armed_q    <= 1'b0;
    end else if (arm_evt) begin
      armed_q    <= 1'b1;
    end else if (!armed_q && ser_tick) begin
      tick_cnt_q <= tick_cnt_q + 1'b1;
    end
  end

  // R2: once armed, the block stays armed until the next reset
  assert_arm_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);

  // R2: arming happens only on a sampled tick
  assert_arm_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(ser_tick));

endmodule

// File: rtl/cts_glitch_filter.sv
module cts_glitch_filter #(
  parameter int FILT_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic load,
  input  logic din,
  output logic level,
  output logic accept_evt
);

  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          level_q;
  logic          differs;

  assign differs    = (din != level_q);
  assign accept_evt = enable && differs && (cnt_q == LAST);
  assign level      = level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b1;
    end else if (load) begin
      cnt_q   <= '0;
      level_q <= din;
    end else if (!enable || !differs) begin
      cnt_q   <= '0;
    end else if (accept_evt) begin
      cnt_q   <= '0;
      level_q <= din;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R5: an armed level change comes only at the end of a full window
  assert_full_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !$past(load) && (level_q != $past(level_q))) |-> ($past(cnt_q) == LAST));

  // R5: the counter never runs past the window
  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R2: before arming, the accepted level stays at its reset value
  assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !load) |=> $stable(level_q));

endmodule

// File: rtl/cts_cos_monitor.sv
module cts_cos_monitor #(
  parameter int FILT_CYCLES = 6,
  parameter int ARM_TICKS   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_tick,
  input  logic       cts_n_async,
  input  logic       stat_rd,
  output logic [7:0] stat_rdata,
  input  logic       aux_wr,
  input  logic [7:0] aux_wdata,
  output logic       irq
);

  import cts_mon_pkg::*;

  logic cts_sync_lvl;
  logic armed;
  logic arm_evt;
  logic lvl;
  logic accept_evt;
  logic set_evt;
  logic flag_q;
  logic irq_en_q;
  logic unused_aux_bits;

  assign unused_aux_bits = ^aux_wdata[7:1];

  cts_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (cts_n_async),
    .q_sync  (cts_sync_lvl)
  );

  cts_startup_arm #(.ARM_TICKS(ARM_TICKS)) u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_tick (ser_tick),
    .armed    (armed),
    .arm_evt  (arm_evt)
  );

  cts_glitch_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (armed),
    .load       (arm_evt),
    .din        (cts_sync_lvl),
    .level      (lvl),
    .accept_evt (accept_evt)
  );

  // A flag set comes from a filtered change or from an asserted line at arming.
  assign set_evt = accept_evt || (arm_evt && !cts_sync_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      flag_q <= next_flag(flag_q, set_evt, stat_rd);
      if (aux_wr) irq_en_q <= aux_wdata[EN_BIT];
    end
  end

  assign stat_rdata = pack_status(flag_q, lvl);
  assign irq        = flag_q && irq_en_q;

  // R2: the level bit reads negated until the block is armed
  assert_unarmed_negated_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> stat_rdata[LVL_BIT]);

  // R4: the flag rises only after a set event
  assert_flag_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_evt));

  // R6: the flag falls only after a status read
  assert_flag_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(stat_rd));

  // R7: a set on the same edge as a read leaves the flag set
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && stat_rd) |=> flag_q);

  // R8: the interrupt needs an enable that was written earlier
  assert_irq_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en_q && flag_q));

  // R9: the reserved bits stay zero in every cycle
  assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[7:5] == 3'b000) && (stat_rdata[3:1] == 3'b000));

endmodule

// File: tb/cts_cos_monitor_bench.sv
module cts_cos_monitor_bench;

  localparam int FILT = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_tick = 1'b0;
  logic       cts_n_async = 1'b1;
  logic       stat_rd = 1'b0;
  logic [7:0] stat_rdata;
  logic       aux_wr = 1'b0;
  logic [7:0] aux_wdata = 8'h00;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  cts_cos_monitor #(.FILT_CYCLES(FILT), .ARM_TICKS(2), .SYNC_STAGES(2)) u_cts_cos_monitor (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_tick    (ser_tick),
    .cts_n_async (cts_n_async),
    .stat_rd     (stat_rd),
    .stat_rdata  (stat_rdata),
    .aux_wr      (aux_wr),
    .aux_wdata   (aux_wdata),
    .irq         (irq)
  );

  // Expected status byte: flag at bit 4, level at bit 0, the rest 0.
  function automatic logic [7:0] exp_status(input logic flag, input logic lvl);
    return (8'(flag) << 4) | 8'(lvl);
  endfunction

  // A pulse is accepted only when it lasts the whole filter window.
  function automatic logic exp_accept(input int width);
    return width >= FILT;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick();
    @(negedge clk); ser_tick = 1'b1;
    @(negedge clk); ser_tick = 1'b0;
  endtask

  // Read strobe: returns the byte seen during the read cycle.
  task automatic do_read(output logic [7:0] val);
    @(negedge clk);
    val = stat_rdata;
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic write_en(input logic en);
    @(negedge clk);
    aux_wr = 1'b1; aux_wdata = {7'h55, en};
    @(negedge clk);
    aux_wr = 1'b0; aux_wdata = 8'h00;
  endtask

  task automatic do_reset(input logic line);
    @(negedge clk);
    rst_n = 1'b0; cts_n_async = line; stat_rd = 1'b0; ser_tick = 1'b0;
    wait_neg(3);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic base;
    void'($urandom(32'd20240611));

    // Startup with the line asserted (low)
    do_reset(1'b0);
    wait_neg(1);
    check("R1 reset status", stat_rdata, 8'h01);
    check("R1 reset irq", {7'd0, irq}, 8'h00);
    wait_neg(3);
    tick();
    check("R2 level held before second tick", stat_rdata, exp_status(1'b0, 1'b1));
    @(negedge clk); ser_tick = 1'b1;
    @(negedge clk); ser_tick = 1'b0;
    check("R3 flag forced at arming, R2 level tracks", stat_rdata, exp_status(1'b1, 1'b0));
    check("R8 irq off while enable is 0", {7'd0, irq}, 8'h00);
    write_en(1'b1);
    check("R8 irq on with flag and enable", {7'd0, irq}, 8'h01);
    do_read(rv);
    check("R6 read returns value before clear", rv, exp_status(1'b1, 1'b0));
    check("R6 flag cleared after read", stat_rdata, exp_status(1'b0, 1'b0));
    check("R8 irq drops with flag", {7'd0, irq}, 8'h00);

    // Startup with the line negated (high)
    do_reset(1'b1);
    wait_neg(1);
    check("R1 enable reset to 0 (irq low)", {7'd0, irq}, 8'h00);
    wait_neg(2);
    tick(); tick();
    check("R3 no flag when line negated at arming", stat_rdata, exp_status(1'b0, 1'b1));

    // Exact latency of an accepted change
    @(negedge clk); cts_n_async = 1'b0;
    wait_neg(FILT + 1);
    check("R4 unchanged one edge early", stat_rdata, exp_status(1'b0, 1'b1));
    wait_neg(1);
    check("R4 change accepted on time", stat_rdata, exp_status(1'b1, 1'b0));
    write_en(1'b1);
    check("R8 irq follows flag", {7'd0, irq}, 8'h01);
    write_en(1'b0);
    check("R8 enable bit 0 cleared turns irq off", {7'd0, irq}, 8'h00);
    do_read(rv);

    // Boundary pulse, one cycle short of the window
    @(negedge clk); cts_n_async = 1'b1;
    wait_neg(FILT - 1);
    cts_n_async = 1'b0;
    wait_neg(FILT + 4);
    check("R5 short pulse ignored", stat_rdata, exp_status(1'b0, 1'b0));

    // Set and read on the same edge; flag was clear before
    @(negedge clk); cts_n_async = 1'b1;
    wait_neg(FILT + 1);
    stat_rd = 1'b1;
    wait_neg(1);
    stat_rd = 1'b0;
    check("R7 set wins over read", stat_rdata, exp_status(1'b1, 1'b1));
    check("R9 reserved bits zero", stat_rdata & 8'hEE, 8'h00);
    do_read(rv);

    // Random pulses of various widths around the window
    for (int it = 0; it < 24; it++) begin
      int w;
      w = 1 + int'($urandom % (2 * FILT));
      base = stat_rdata[0];
      @(negedge clk); cts_n_async = ~base;
      wait_neg(w);
      cts_n_async = base;
      wait_neg(FILT + 4);
      do_read(rv);
      check($sformatf("R5/R4 random pulse width %0d", w), rv, exp_status(exp_accept(w), base));
      check("R9 reserved bits zero (random)", rv & 8'hEE, 8'h00);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule